// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one NAND bus operation at a time on an 8-bit NAND interface, under control of a small host register port. The host loads a command byte or an address byte into a holding register, then writes a start code into the control register. The engine issues a single command latch cycle, a single address latch cycle, a full page program burst taken from an internal page buffer, or a read transfer that fills that buffer. Completion is reported through a done flag and an optional interrupt pulse.

The page buffer holds a 512-byte main section followed by a 16-byte spare section. Page transfers move the main bytes first and the spare bytes after them. A read transfer carries a type code: a full page, one device ID byte, or one status byte. The single-byte types land in buffer byte 0. Software reads that byte to decide what it means: bit 0 set after a program is a failure, and bit 7 clear means the part is write-protected. The host reads and writes the buffer through a byte-wide side port while the engine is idle.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the done flag (control register bit 15) reads 1. CE#, WE# and RE# are high, CLE and ALE are low, and the interrupt output is low.
- R2: Writing control value 0x0001 (bit 0) issues exactly one WE# pulse with CLE high and ALE low, driving bits [7:0] of the command holding register (register address 0). The done flag reads 0 from the write until the pulse completes.
- R3: Writing control value 0x0002 (bit 1) issues exactly one WE# pulse with ALE high and CLE low, driving bits [7:0] of the address holding register (register address 1). CLE and ALE are never high together.
- R4: The read type code sits in control bits [5:3]. Value 1 reads a page: 528 RE# pulses, with the byte captured in pulse i stored at buffer index i, so main bytes go to 0..511 and spare bytes to 512..527. Value 2 (device ID) and value 4 (status) read one byte into buffer index 0 and leave the other entries unchanged. The data bus is never driven while RE# is low.
- R5: Writing control value 0x0004 (bit 2) issues 528 WE# pulses that drive buffer bytes 0..527 in index order. Host buffer writes are ignored while an operation is in progress.
- R6: Each WE# or RE# pulse is low for PULSE_CLKS clocks, and consecutive pulses are separated by PULSE_CLKS high clocks. CE# is low from the start of an operation until the done flag sets.
- R7: After the last pulse of a page program or a page read, the done flag stays 0 while ready/busy is low, and sets once it is high.
- R8: A control write is ignored (no bus activity, done flag unchanged) while done is 0. It is also ignored when it holds no valid code, that is, more than one of bits [2:0] set, a read type other than 1, 2 or 4, or both a start bit and a type.
- R9: Writing 1 to configuration bit 0 (register address 3) aborts any operation, returns the pins to idle and sets the done flag. The bit reads back as 0 afterwards.
- R10: The interrupt output pulses high for one clock when an operation completes, unless configuration bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 address, 2 control, 3 configuration |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| buf_we | input | 1 | Host buffer byte write strobe |
| buf_addr | input | 10 | Host buffer byte index |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer read byte (combinational) |
| irq | output | 1 | Completion interrupt pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The bench holds ready/busy low after page transfers to catch a design that reports done on the final strobe instead of waiting for the device. It fires start writes during a long page read. A design that accepted them would corrupt the burst and emit a stray CLE pulse. It writes malformed control codes that a loose decoder would act on, and it checks buffer placement at the 511/512 boundary, where a wrong spare offset shows as mismatched bytes. It also aborts a read in mid-strobe and checks that the pins go idle and that done returns without an interrupt.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_CMD, OP_ADR, OP_DIN, OP_RD_PAGE, OP_RD_ID, OP_RD_STAT
  } op_e;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_ADR  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_CFG  = 2'd3;

  // Start codes: bits [2:0] one-hot start, bits [5:3] read type; never both.
  function automatic op_e decode_start(input logic [15:0] w);
    logic [2:0] s;
    logic [2:0] t;
    op_e r;
    s = w[2:0];
    t = w[5:3];
    r = OP_NONE;
    if (t == 3'd0) begin
      case (s)
        3'b001:  r = OP_CMD;
        3'b010:  r = OP_ADR;
        3'b100:  r = OP_DIN;
        default: r = OP_NONE;
      endcase
    end else if (s == 3'd0) begin
      case (t)
        3'd1:    r = OP_RD_PAGE;
        3'd2:    r = OP_RD_ID;
        3'd4:    r = OP_RD_STAT;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic int unsigned xfer_len(input op_e op, input int unsigned main_b,
                                           input int unsigned spare_b);
    return (op == OP_DIN || op == OP_RD_PAGE) ? main_b + spare_b : 1;
  endfunction

  function automatic logic waits_ready(input op_e op);
    return op == OP_DIN || op == OP_RD_PAGE;
  endfunction

  function automatic logic is_write(input op_e op);
    return op == OP_CMD || op == OP_ADR || op == OP_DIN;
  endfunction

  function automatic logic is_read(input op_e op);
    return op == OP_RD_PAGE || op == OP_RD_ID || op == OP_RD_STAT;
  endfunction

endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int unsigned DEPTH = 528,
  parameter int unsigned AW    = 10
) (
  input  logic          clk,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_idx,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  input  logic          host_we,
  input  logic          host_ok,
  input  logic [AW-1:0] host_idx,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);
  logic [7:0] mem [DEPTH];
  logic eng_in, host_in;

  assign eng_in  = {1'b0, eng_idx}  < (AW+1)'(DEPTH);
  assign host_in = {1'b0, host_idx} < (AW+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (eng_we && eng_in)
      mem[eng_idx] <= eng_wdata;
    else if (host_we && host_ok && host_in)
      mem[host_idx] <= host_wdata;
  end

  assign eng_rdata  = eng_in  ? mem[eng_idx]  : 8'h00;
  assign host_rdata = host_in ? mem[host_idx] : 8'h00;
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        op_finish,
  output logic        start_go,
  output op_e         start_op,
  output logic        soft_rst,
  output logic [7:0]  cmd_byte,
  output logic [7:0]  adr_byte,
  output logic        done,
  output logic        irq
);
  logic [15:0] cmd_q, adr_q;
  logic done_q, irq_dis_q, srst_q, irq_q;
  logic wr_ctrl;

  assign wr_ctrl  = reg_we && reg_addr == RA_CTRL;
  assign start_op = decode_start(reg_wdata);
  assign start_go = wr_ctrl && done_q && !srst_q && start_op != OP_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; adr_q <= '0; done_q <= 1'b1;
      irq_dis_q <= 1'b0; srst_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q  <= op_finish && !irq_dis_q && !srst_q;
      srst_q <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          RA_CMD: cmd_q <= reg_wdata;
          RA_ADR: adr_q <= reg_wdata;
          RA_CFG: begin irq_dis_q <= reg_wdata[1]; srst_q <= reg_wdata[0]; end
          default: ;
        endcase
      end
      if (srst_q)         done_q <= 1'b1;
      else if (start_go)  done_q <= 1'b0;
      else if (op_finish) done_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CMD:  reg_rdata = cmd_q;
      RA_ADR:  reg_rdata = adr_q;
      RA_CTRL: reg_rdata = {done_q, 15'd0};
      default: reg_rdata = {14'd0, irq_dis_q, srst_q};
    endcase
  end

  assign soft_rst = srst_q;
  assign cmd_byte = cmd_q[7:0];
  assign adr_byte = adr_q[7:0];
  assign done     = done_q;
  assign irq      = irq_q;

  // R2: an accepted start drops the done flag on the next cycle
  p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !done_q);
  // R9: a soft reset request leaves the block reporting done
  p_srst_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (done_q && !irq_q));
  // R10: the interrupt is a single-cycle pulse
  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/nand_op_fsm.sv
module nand_op_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned MAIN_BYTES  = 512,
  parameter int unsigned SPARE_BYTES = 16,
  parameter int unsigned PULSE_CLKS  = 2,
  parameter int unsigned AW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          start_go,
  input  op_e           start_op,
  input  logic [7:0]    cmd_byte,
  input  logic [7:0]    adr_byte,
  input  logic [7:0]    buf_rdata,
  output logic [AW-1:0] buf_idx,
  output logic          cap_we,
  output logic          op_finish,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_dq_o,
  output logic          nand_dq_oe,
  input  logic          nand_rb
);
  localparam int unsigned TW = $clog2(PULSE_CLKS + 1);
  localparam int unsigned LW = $clog2(PULSE_CLKS + 2);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_RB} phase_e;

  phase_e        st;
  op_e           op_q;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] bidx;
  logic          active, phase_end, last_byte;

  always_comb begin
    active    = st == S_LO || st == S_HI;
    phase_end = active && tcnt == TW'(PULSE_CLKS - 1);
    last_byte = bidx == AW'(xfer_len(op_q, MAIN_BYTES, SPARE_BYTES) - 1);
    op_finish = (st == S_HI && phase_end && last_byte && !waits_ready(op_q)) ||
                (st == S_RB && nand_rb);
    cap_we    = st == S_LO && phase_end && is_read(op_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_NONE; tcnt <= '0; bidx <= '0;
    end else if (soft_rst) begin
      st <= S_IDLE; op_q <= OP_NONE; tcnt <= '0; bidx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_go) begin
          st <= S_LO; op_q <= start_op; tcnt <= '0; bidx <= '0;
        end
        S_LO: if (phase_end) begin
          st <= S_HI; tcnt <= '0;
        end else tcnt <= tcnt + TW'(1);
        S_HI: if (phase_end) begin
          tcnt <= '0;
          if (!last_byte) begin
            bidx <= bidx + AW'(1);
            st   <= S_LO;
          end else st <= waits_ready(op_q) ? S_RB : S_IDLE;
        end else tcnt <= tcnt + TW'(1);
        default: if (nand_rb) st <= S_IDLE;
      endcase
    end
  end

  assign buf_idx    = bidx;
  assign nand_ce_n  = st == S_IDLE;
  assign nand_cle   = active && op_q == OP_CMD;
  assign nand_ale   = active && op_q == OP_ADR;
  assign nand_we_n  = !(st == S_LO && is_write(op_q));
  assign nand_re_n  = !(st == S_LO && is_read(op_q));
  assign nand_dq_oe = active && is_write(op_q);
  assign nand_dq_o  = op_q == OP_CMD ? cmd_byte :
                      op_q == OP_ADR ? adr_byte : buf_rdata;

  // Checker state: length of the current strobe-low run.
  logic          strobe_idle;
  logic [LW-1:0] lo_run;
  assign strobe_idle = nand_we_n && nand_re_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_run <= '0;
    else if (strobe_idle) lo_run <= '0;
    else                  lo_run <= lo_run + LW'(1);
  end

  // R6: every completed strobe was low for exactly PULSE_CLKS cycles
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_idle) && !$past(soft_rst)) |-> lo_run == LW'(PULSE_CLKS));
  // R3: latch enables are exclusive, strobes are exclusive
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nand_cle, nand_ale}) && (nand_we_n || nand_re_n));
  // R4: never drive the bus while the device drives it
  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  // R7: page operations finish only with the device ready
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_finish && waits_ready(op_q)) |-> nand_rb);
  // R8: new operations are accepted only from idle
  p_start_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> st == S_IDLE);
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned MAIN_BYTES  = 512,
  parameter int unsigned SPARE_BYTES = 16,
  parameter int unsigned PULSE_CLKS  = 2,
  parameter int unsigned BUF_AW      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              irq,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb
);
  localparam int unsigned BUF_BYTES = MAIN_BYTES + SPARE_BYTES;

  logic              start_go, soft_rst, op_finish, done, cap_we;
  op_e               start_op;
  logic [7:0]        cmd_byte, adr_byte, eng_rdata;
  logic [BUF_AW-1:0] eng_idx;

  nand_host_regs i_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .op_finish, .start_go, .start_op, .soft_rst,
    .cmd_byte, .adr_byte, .done, .irq
  );

  nand_op_fsm #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .PULSE_CLKS(PULSE_CLKS), .AW(BUF_AW)
  ) i_fsm (
    .clk, .rst_n, .soft_rst, .start_go, .start_op, .cmd_byte, .adr_byte,
    .buf_rdata(eng_rdata), .buf_idx(eng_idx), .cap_we, .op_finish,
    .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
    .nand_dq_o, .nand_dq_oe, .nand_rb
  );

  nand_page_buf #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) i_buf (
    .clk,
    .eng_we(cap_we), .eng_idx, .eng_wdata(nand_dq_i), .eng_rdata,
    .host_we(buf_we), .host_ok(done), .host_idx(buf_addr),
    .host_wdata(buf_wdata), .host_rdata(buf_rdata)
  );
endmodule

// File: tb/test_nand_op_seq.sv
`timescale 1ns/1ps
module test_nand_op_seq;
  localparam int PULSE = 2;
  localparam int TOTAL = 528;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic buf_we = 1'b0;
  logic [9:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic nand_rb = 1'b1;

  always #2 clk = ~clk;

  nand_op_seq i_nand_op_seq (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .buf_we, .buf_addr, .buf_wdata, .buf_rdata, .irq,
    .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n,
    .nand_dq_o, .nand_dq_oe, .nand_dq_i, .nand_rb
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_rd(input int i, input logic [7:0] s);
    return 8'((i * 7 + int'(s)) & 255);
  endfunction
  function automatic logic [7:0] pat_wr(input int i);
    return 8'((i * 5 + 3 + (i >> 8)) & 255);
  endfunction

  // NAND model and bus monitor, sampled on the falling edge.
  logic [7:0] seed = 8'h00;
  int rd_cnt = 0, wr_n = 0, cle_n = 0, ale_n = 0, irq_n = 0;
  int lo_len = 0, hi_len = 0, width_bad = 0, gap_bad = 0;
  bit armed = 0, prev_low = 0, skip_width = 0;
  bit lat_we = 0, lat_cle = 0, lat_ale = 0, last_cle = 0, last_ale = 0;
  logic [7:0] lat_dq = '0;
  logic [7:0] wr_log [1024];

  assign nand_dq_i = pat_rd(rd_cnt, seed);

  always @(negedge clk) begin
    bit low_now;
    low_now = !nand_we_n || !nand_re_n;
    if (low_now && !prev_low) begin
      if (armed && hi_len != PULSE && !skip_width) gap_bad++;
      lo_len = 1; armed = 0;
    end else if (low_now) lo_len++;
    if (!low_now && prev_low) begin
      if (lo_len != PULSE && !skip_width) width_bad++;
      hi_len = 1; armed = 1;
      if (lat_we) begin
        wr_log[wr_n % 1024] = lat_dq; wr_n++;
        if (lat_cle) cle_n++;
        if (lat_ale) ale_n++;
        last_cle = lat_cle; last_ale = lat_ale;
      end else rd_cnt++;
    end else if (!low_now) hi_len++;
    if (!nand_we_n) begin
      lat_we = 1; lat_dq = nand_dq_o; lat_cle = nand_cle; lat_ale = nand_ale;
    end
    if (!nand_re_n) lat_we = 0;
    if (nand_ce_n) begin armed = 0; rd_cnt = 0; end
    if (irq) irq_n++;
    prev_low = low_now;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic wr_buf(input int i, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_addr = 10'(i); buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask
  task automatic rd_buf(input int i, output logic [7:0] d);
    buf_addr = 10'(i); #1; d = buf_rdata;
  endtask
  task automatic wait_done(input string tag);
    logic [15:0] v;
    v = '0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); rd_reg(2'd2, v);
      if (v[15]) break;
    end
    chk(v[15], tag, v[15], 1);
  endtask

  localparam logic [16:0] VEC [4] = '{17'h0_0070, 17'h0_AB90, 17'h1_0000, 17'h1_12FF};

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] b;
    int base, mism, c0;

    // R1: reset state
    repeat (3) @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[15] === 1'b1, "R1 done in reset", v[15], 1);
    rst_n = 1;
    @(negedge clk);
    chk({nand_ce_n, nand_we_n, nand_re_n} === 3'b111, "R1 strobes idle",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk({nand_cle, nand_ale, irq} === 3'b000, "R1 latches low",
        {nand_cle, nand_ale, irq}, 0);

    // R2 / R3: table of single command and address cycles
    foreach (VEC[n]) begin
      bit is_adr;
      is_adr = VEC[n][16];
      wr_reg(is_adr ? 2'd1 : 2'd0, VEC[n][15:0]);
      base = wr_n;
      wr_reg(2'd2, is_adr ? 16'h0002 : 16'h0001);
      rd_reg(2'd2, v);
      chk(v[15] === 1'b0, "R2 done cleared by start", v[15], 0);
      wait_done("R2 single cycle completes");
      chk(wr_n == base + 1, is_adr ? "R3 one address pulse" : "R2 one command pulse",
          wr_n - base, 1);
      chk(wr_log[base % 1024] == VEC[n][7:0], is_adr ? "R3 address byte" : "R2 command byte",
          wr_log[base % 1024], VEC[n][7:0]);
      chk({last_cle, last_ale} == (is_adr ? 2'b01 : 2'b10),
          is_adr ? "R3 ALE only" : "R2 CLE only", {last_cle, last_ale}, is_adr ? 1 : 2);
    end
    chk(nand_ce_n === 1'b1, "R6 CE released at done", nand_ce_n, 1);

    // R4: status and ID reads land in byte 0 only
    wr_buf(1, 8'h77);
    seed = 8'hC0;
    wr_reg(2'd2, 16'h0020);
    wait_done("R4 status read completes");
    rd_buf(0, b); chk(b == 8'hC0, "R4 status byte", b, 8'hC0);
    seed = 8'h2C;
    wr_reg(2'd2, 16'h0010);
    wait_done("R4 id read completes");
    rd_buf(0, b); chk(b == 8'h2C, "R4 id byte", b, 8'h2C);
    rd_buf(1, b); chk(b == 8'h77, "R4 byte 1 untouched", b, 8'h77);

    // R4 / R7 / R8: page read, busy hold, start attempts while busy
    seed = 8'h11; nand_rb = 0;
    c0 = cle_n;
    wr_reg(2'd2, 16'h0008);
    repeat (40) @(negedge clk);
    wr_reg(2'd0, 16'h00FF);
    wr_reg(2'd2, 16'h0001);
    wr_reg(2'd2, 16'h0004);
    for (int k = 0; k < 5000 && rd_cnt < TOTAL; k++) @(negedge clk);
    chk(rd_cnt == TOTAL, "R4 page read strobe count", rd_cnt, TOTAL);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[15] === 1'b0, "R7 done held while busy", v[15], 0);
    nand_rb = 1;
    wait_done("R7 page read done after ready");
    chk(cle_n == c0, "R8 start while busy ignored", cle_n - c0, 0);
    mism = 0;
    for (int i = 0; i < TOTAL; i++) begin
      rd_buf(i, b);
      if (b != pat_rd(i, 8'h11)) mism++;
    end
    chk(mism == 0, "R4 page bytes in order", mism, 0);
    rd_buf(511, b); chk(b == pat_rd(511, 8'h11), "R4 last main byte", b, pat_rd(511, 8'h11));
    rd_buf(512, b); chk(b == pat_rd(512, 8'h11), "R4 first spare byte", b, pat_rd(512, 8'h11));

    // R5: page program from buffer
    for (int i = 0; i < TOTAL; i++) wr_buf(i, pat_wr(i));
    nand_rb = 0;
    base = wr_n;
    wr_reg(2'd2, 16'h0004);
    for (int k = 0; k < 5000 && wr_n < base + TOTAL; k++) @(negedge clk);
    chk(wr_n - base == TOTAL, "R5 program strobe count", wr_n - base, TOTAL);
    wr_buf(0, 8'hEE);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[15] === 1'b0, "R7 program done held while busy", v[15], 0);
    nand_rb = 1;
    wait_done("R7 program done after ready");
    mism = 0;
    for (int i = 0; i < TOTAL; i++)
      if (wr_log[(base + i) % 1024] != pat_wr(i)) mism++;
    chk(mism == 0, "R5 program bytes in order", mism, 0);
    rd_buf(0, b); chk(b == pat_wr(0), "R5 host write while busy ignored", b, pat_wr(0));

    // R8: malformed control codes
    base = wr_n; c0 = rd_cnt;
    wr_reg(2'd2, 16'h0003);
    wr_reg(2'd2, 16'h0018);
    wr_reg(2'd2, 16'h0009);
    wr_reg(2'd2, 16'h0000);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[15] === 1'b1, "R8 invalid code leaves done", v[15], 1);
    chk(wr_n == base && nand_ce_n === 1'b1, "R8 invalid code no bus activity", wr_n - base, 0);

    // R10: interrupt pulse and mask
    c0 = irq_n;
    wr_reg(2'd2, 16'h0001);
    wait_done("R10 cmd done");
    @(negedge clk);
    chk(irq_n == c0 + 1, "R10 one irq pulse", irq_n - c0, 1);
    wr_reg(2'd3, 16'h0002);
    c0 = irq_n;
    wr_reg(2'd2, 16'h0001);
    wait_done("R10 masked cmd done");
    @(negedge clk);
    chk(irq_n == c0, "R10 masked irq", irq_n - c0, 0);
    wr_reg(2'd3, 16'h0000);

    // R9: soft reset aborts a page read
    skip_width = 1; nand_rb = 0;
    c0 = irq_n;
    wr_reg(2'd2, 16'h0008);
    repeat (21) @(negedge clk);
    wr_reg(2'd3, 16'h0001);
    @(negedge clk);
    rd_reg(2'd2, v);
    chk(v[15] === 1'b1, "R9 done after soft reset", v[15], 1);
    chk({nand_ce_n, nand_re_n, nand_we_n} === 3'b111, "R9 pins idle",
        {nand_ce_n, nand_re_n, nand_we_n}, 7);
    rd_reg(2'd3, v);
    chk(v[0] === 1'b0, "R9 reset bit self clears", v[0], 0);
    chk(irq_n == c0, "R9 no irq on abort", irq_n - c0, 0);
    repeat (4) @(negedge clk);
    skip_width = 0; nand_rb = 1;
    wr_reg(2'd0, 16'h0030);
    base = wr_n;
    wr_reg(2'd2, 16'h0001);
    wait_done("R9 usable after abort");
    chk(wr_log[base % 1024] == 8'h30, "R9 command after abort", wr_log[base % 1024], 8'h30);

    chk(width_bad == 0, "R6 strobe low width", width_bad, 0);
    chk(gap_bad == 0, "R6 strobe high gap", gap_bad, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule